// File: doc/BRIEF.md
# Stochastic Two-Column Hit Allocator

This block sits between a waveform point stream and the bitmap writer of a raster display. Each incoming point names a bitmap column, a sub-column horizontal position and an 8-bit amplitude. The block emits one hit record per point. The record holds the column that receives the hit, the row (the amplitude itself) and a brightness value.

The target column is chosen at random between the point's own column and its right neighbour. The chance of taking the neighbour grows with how far the point sits across its column. Over many superimposed waveforms this breaks the fixed relation between signal timing and the pixel grid, which would otherwise show up as interference stripes.

Brightness is the absolute amplitude change from the previous accepted point, so steep edges are drawn brighter. A start strobe marks the first point of a waveform, which has no predecessor. Points enter through a valid/ready handshake. Hits leave through a registered valid/ready output stage.

Top module: `stoch_hit_alloc`

## Requirements
- R1: While reset is high and on the first cycle after it, `hit_valid` is 0 and `pt_ready` is 1.
- R2: For an accepted point, `hit_col` is `pt_col + 1` when the random value is strictly below `pt_frac`, and `pt_col` otherwise. The random value is bits [7:0] of the generator state just before that acceptance.
- R3: The generator is a 16-bit register that shifts left, with the XOR of bits 15, 13, 12 and 10 fed into bit 0. Reset loads it with 16'hACE1. It steps exactly once per accepted point and holds in every other cycle.
- R4: A point with `pt_frac` equal to 0 always lands in its own column.
- R5: A point in column 255 always lands in column 255, whatever its fraction.
- R6: `hit_row` equals the amplitude of the point that produced the hit.
- R7: `hit_bright` equals the absolute difference between the point's amplitude and the amplitude of the previously accepted point.
- R8: `hit_bright` is 0 for a point accepted with `pt_start` high, and for the first point accepted after reset.
- R9: `pt_ready` equals `!hit_valid || hit_ready`. While `hit_valid` is 1 and `hit_ready` is 0, every hit output holds its value.
- R10: Over 1000 points with fraction 153 (about 60%), the number of hits placed in the right-hand column lies between 520 and 680.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_valid | input | 1 | Input point present |
| pt_ready | output | 1 | Block can take a point this cycle |
| pt_start | input | 1 | Point is the first of a new waveform |
| pt_col | input | 8 | Column index of the point |
| pt_frac | input | 8 | Position inside the column, 0 = left edge |
| pt_amp | input | 8 | Amplitude sample |
| hit_valid | output | 1 | Hit record present |
| hit_ready | input | 1 | Downstream takes the hit |
| hit_col | output | 8 | Column receiving the hit |
| hit_row | output | 8 | Row of the hit |
| hit_bright | output | 8 | Brightness of the hit |

## Verification
The bench keeps its own model of the shift register. It predicts every column choice exactly, so a wrong tap, seed, compare direction (less-than-or-equal instead of less-than) or bit slice shows up as a misplaced hit within a few points. A stall sequence checks two things: that the generator does not advance while no point is taken, and that the output stays frozen. A design that steps on every clock would drift from the model right after the stall.

Further cases cover:
- column 255, where a design without the edge guard wraps the hit to column 0;
- fraction 0, which must never move the hit;
- the start strobe, where a design that keeps the previous amplitude across waveforms produces a spurious bright first hit;
- amplitude descents, which a design that forgot the absolute value would report as huge brightness.

// File: rtl/hit_alloc_pkg.sv
package hit_alloc_pkg;
  localparam int unsigned DEF_COL_W  = 8;
  localparam int unsigned DEF_FRAC_W = 8;
  localparam int unsigned DEF_AMP_W  = 8;
  localparam int unsigned DEF_RNG_W  = 16;
  localparam logic [15:0] DEF_TAPS   = 16'hB400;
  localparam logic [15:0] DEF_SEED   = 16'hACE1;

  typedef enum logic {
    PICK_SAME = 1'b0,
    PICK_NEXT = 1'b1
  } col_pick_e;
endpackage

// File: rtl/hit_alloc_rng.sv
module hit_alloc_rng #(
  parameter int unsigned W     = 16,
  parameter int unsigned OUT_W = 8,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] state;
  logic         fb;

  assign fb  = ^(state & TAPS);
  assign rnd = state[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)          state <= SEED;
    else if (advance) state <= {state[W-2:0], fb};
  end

  // R3
  rng_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state != '0);
  // R3
  rng_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(state));
  // R3
  rng_moves_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> state == {$past(state[W-2:0]), $past(fb)});
endmodule

// File: rtl/hit_alloc_colsel.sv
module hit_alloc_colsel
  import hit_alloc_pkg::*;
#(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned FRAC_W = 8
) (
  input  logic [COL_W-1:0]  col_in,
  input  logic [FRAC_W-1:0] frac,
  input  logic [FRAC_W-1:0] rnd,
  output col_pick_e         pick,
  output logic [COL_W-1:0]  col_out
);
  localparam logic [COL_W-1:0] LAST_COL = {COL_W{1'b1}};

  logic at_edge;
  logic wants_next;

  assign at_edge    = (col_in == LAST_COL);
  assign wants_next = (rnd < frac);

  always_comb begin
    pick = PICK_SAME;
    if (wants_next && !at_edge) pick = PICK_NEXT;
  end

  assign col_out = (pick == PICK_NEXT) ? col_in + COL_W'(1) : col_in;

  // R5
  edge_stay_chk: assert final (!at_edge || col_out == LAST_COL);
endmodule

// File: rtl/hit_alloc_step.sv
module hit_alloc_step #(
  parameter int unsigned AMP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             first,
  input  logic [AMP_W-1:0] amp,
  output logic [AMP_W-1:0] step
);
  logic [AMP_W-1:0] prev_amp;
  logic             have_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_amp  <= '0;
      have_prev <= 1'b0;
    end else if (load) begin
      prev_amp  <= amp;
      have_prev <= 1'b1;
    end
  end

  always_comb begin
    if (first || !have_prev) step = '0;
    else if (amp >= prev_amp) step = amp - prev_amp;
    else                      step = prev_amp - amp;
  end

  // R8
  step_fresh_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> have_prev);
endmodule

// File: rtl/stoch_hit_alloc.sv
module stoch_hit_alloc
  import hit_alloc_pkg::*;
#(
  parameter int unsigned COL_W  = DEF_COL_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  parameter int unsigned AMP_W  = DEF_AMP_W,
  parameter int unsigned RNG_W  = DEF_RNG_W,
  parameter logic [RNG_W-1:0] RNG_TAPS = DEF_TAPS,
  parameter logic [RNG_W-1:0] RNG_SEED = DEF_SEED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pt_valid,
  output logic              pt_ready,
  input  logic              pt_start,
  input  logic [COL_W-1:0]  pt_col,
  input  logic [FRAC_W-1:0] pt_frac,
  input  logic [AMP_W-1:0]  pt_amp,
  output logic              hit_valid,
  input  logic              hit_ready,
  output logic [COL_W-1:0]  hit_col,
  output logic [AMP_W-1:0]  hit_row,
  output logic [AMP_W-1:0]  hit_bright
);
  localparam logic [COL_W-1:0] LAST_COL = {COL_W{1'b1}};

  logic              take;
  logic [FRAC_W-1:0] rnd;
  col_pick_e         pick;
  logic [COL_W-1:0]  sel_col;
  logic [AMP_W-1:0]  step;

  assign pt_ready = !hit_valid || hit_ready;
  assign take     = pt_valid && pt_ready;

  hit_alloc_rng #(
    .W(RNG_W), .OUT_W(FRAC_W), .TAPS(RNG_TAPS), .SEED(RNG_SEED)
  ) u_rng (
    .clk(clk), .rst(rst), .advance(take), .rnd(rnd)
  );

  hit_alloc_colsel #(.COL_W(COL_W), .FRAC_W(FRAC_W)) u_colsel (
    .col_in(pt_col), .frac(pt_frac), .rnd(rnd), .pick(pick), .col_out(sel_col)
  );

  hit_alloc_step #(.AMP_W(AMP_W)) u_step (
    .clk(clk), .rst(rst), .load(take), .first(pt_start), .amp(pt_amp), .step(step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid  <= 1'b0;
      hit_col    <= '0;
      hit_row    <= '0;
      hit_bright <= '0;
    end else begin
      if (take) begin
        hit_valid  <= 1'b1;
        hit_col    <= sel_col;
        hit_row    <= pt_amp;
        hit_bright <= step;
      end else if (hit_ready) begin
        hit_valid  <= 1'b0;
      end
    end
  end

  // R2
  col_pair_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (hit_col == $past(pt_col)) || (hit_col == COL_W'($past(pt_col) + 1'b1)));
  // R4
  frac_zero_chk: assert property (@(posedge clk) disable iff (rst)
    take && pt_frac == '0 |=> hit_col == $past(pt_col));
  // R5
  last_col_chk: assert property (@(posedge clk) disable iff (rst)
    take && pt_col == LAST_COL |=> hit_col == LAST_COL);
  // R6
  row_copy_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> hit_valid && hit_row == $past(pt_amp));
  // R8
  start_dark_chk: assert property (@(posedge clk) disable iff (rst)
    take && pt_start |=> hit_bright == '0);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hit_valid && !hit_ready |=> hit_valid && $stable(hit_col) && $stable(hit_row) && $stable(hit_bright));
endmodule

// File: tb/stoch_hit_alloc_bench.sv
module stoch_hit_alloc_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pt_valid = 1'b0, pt_start = 1'b0, hit_ready = 1'b1;
  logic [7:0] pt_col = '0, pt_frac = '0, pt_amp = '0;
  logic pt_ready, hit_valid;
  logic [7:0] hit_col, hit_row, hit_bright;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_state;
  logic [7:0]  m_prev;
  bit          m_have;

  always #2.5 clk = ~clk;

  stoch_hit_alloc u_stoch_hit_alloc (
    .clk(clk), .rst(rst), .pt_valid(pt_valid), .pt_ready(pt_ready),
    .pt_start(pt_start), .pt_col(pt_col), .pt_frac(pt_frac), .pt_amp(pt_amp),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_col(hit_col),
    .hit_row(hit_row), .hit_bright(hit_bright)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rng_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] c, input logic [7:0] f, input logic [7:0] r);
    return (c != 8'hFF && r < f) ? c + 8'd1 : c;
  endfunction

  function automatic logic [7:0] exp_bright(input logic [7:0] a, input bit st);
    if (st || !m_have) return 8'd0;
    return (a >= m_prev) ? a - m_prev : m_prev - a;
  endfunction

  // Sends one point with hit_ready high and checks the hit one cycle later.
  task automatic send(input logic [7:0] c, input logic [7:0] f, input logic [7:0] a,
                      input bit st, input string tag, output bit went_next);
    logic [7:0] ec, eb;
    @(negedge clk);
    pt_valid = 1'b1; pt_col = c; pt_frac = f; pt_amp = a; pt_start = st;
    ec = exp_col(c, f, m_state[7:0]);
    eb = exp_bright(a, st);
    went_next = (ec != c);
    m_state = rng_next(m_state); m_prev = a; m_have = 1'b1;
    @(negedge clk);
    pt_valid = 1'b0; pt_start = 1'b0;
    chk(hit_valid, {tag, " valid"}, hit_valid, 1);
    chk(hit_col == ec, {tag, " col"}, hit_col, ec);
    chk(hit_row == a, {"R6 ", tag, " row"}, hit_row, a);
    chk(hit_bright == eb, {tag, " bright"}, hit_bright, eb);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_state = 16'hACE1; m_have = 1'b0; m_prev = '0;
    chk(!hit_valid, "R1 valid after reset", hit_valid, 0);
    chk(pt_ready, "R1 ready after reset", pt_ready, 1);
  endtask

  task automatic t_bright();
    bit n;
    send(8'd20, 8'd100, 8'd100, 1'b0, "R8 first after reset", n);
    send(8'd21, 8'd100, 8'd130, 1'b0, "R7 rise", n);
    send(8'd22, 8'd100, 8'd90,  1'b0, "R7 fall", n);
    send(8'd23, 8'd100, 8'd250, 1'b1, "R8 start strobe", n);
    send(8'd24, 8'd100, 8'd5,   1'b0, "R7 big fall", n);
  endtask

  task automatic t_edges();
    bit n;
    for (int i = 0; i < 20; i++) begin
      send(8'hFF, 8'hFF, 8'(i * 7), 1'b0, "R5 last column", n);
      chk(hit_col == 8'hFF, "R5 stays at 255", hit_col, 255);
    end
    for (int i = 0; i < 20; i++) begin
      send(8'd40, 8'd0, 8'(i * 3), 1'b0, "R4 zero fraction", n);
      chk(hit_col == 8'd40, "R4 own column", hit_col, 40);
    end
    for (int i = 0; i < 20; i++) send(8'(i * 11), 8'(i * 13), 8'(i), 1'b0, "R2 mixed", n);
  endtask

  task automatic t_stall();
    logic [7:0] ec;
    bit n;
    @(negedge clk);
    hit_ready = 1'b0;
    pt_valid = 1'b1; pt_col = 8'd50; pt_frac = 8'd128; pt_amp = 8'd60; pt_start = 1'b0;
    ec = exp_col(8'd50, 8'd128, m_state[7:0]);
    m_state = rng_next(m_state); m_prev = 8'd60;
    @(negedge clk);
    pt_col = 8'd51; pt_amp = 8'd70;
    chk(!pt_ready, "R9 ready low on stall", pt_ready, 0);
    repeat (4) @(negedge clk);
    chk(hit_valid && hit_col == ec, "R9 col held", hit_col, ec);
    chk(hit_row == 8'd60, "R9 row held", hit_row, 60);
    hit_ready = 1'b1;
    ec = exp_col(8'd51, 8'd128, m_state[7:0]);
    m_state = rng_next(m_state); m_prev = 8'd70;
    @(negedge clk);
    pt_valid = 1'b0;
    chk(hit_col == ec, "R3 no step while stalled", hit_col, ec);
    chk(hit_bright == 8'd10, "R7 after stall", hit_bright, 10);
    @(negedge clk);
    chk(!hit_valid, "R9 drains", hit_valid, 0);
    send(8'd52, 8'd200, 8'd70, 1'b0, "R3 after stall", n);
  endtask

  task automatic t_stats();
    int nxt = 0;
    bit n;
    for (int i = 0; i < 1000; i++) begin
      send(8'd10, 8'd153, 8'd128, 1'b0, "R2 stats", n);
      if (n) nxt++;
    end
    chk(nxt >= 520 && nxt <= 680, "R10 right-column share", nxt, 612);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_bright();
    t_edges();
    t_stall();
    t_stats();
    t_reset();
    t_bright();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule